// File: doc/BRIEF.md
# Continuously Tracking Receive Gain Controller with Software Freeze

This block sets the gain of a secondary receive path that watches the spectrum at all times. It does not wait for a packet-detect event. For each accepted sample it takes an RSSI value and a signed I/Q pair, and it drives a 6-bit gain code to the radio. A sample that reaches the converter's full scale lowers the gain, and so does a sudden rise of RSSI above a filtered baseline. If RSSI stays quiet for long enough, the gain rises one step at a time.

Software can assert a hold input to freeze the gain during a capture window. Releasing hold lets tracking resume from the frozen code. After every gain change, a per-sample stable flag drops for a programmable number of samples. Downstream capture logic uses this flag to discard samples taken while the front end settles.

Top module: `agc_track`

## Requirements
- R1: After reset, `gain_code` is GAIN_INIT (32 by default) and `gain_stable` is 1.
- R2: A sample is saturated if either component is at least +2^(SW-1)-1 or at most -(2^(SW-1)-1). An accepted saturated sample lowers the gain by `cfg_gain_step` on the next clock. The result is clamped at `cfg_gain_min`.
- R3: A baseline register, which resets to 0, follows RSSI on each accepted sample as base += floor((rssi-base)/8). A sample with rssi > base + `cfg_step_thr` is a jump. A jump lowers the gain by one step and loads the baseline with that rssi.
- R4: The gain rises by one step, clamped at `cfg_gain_max`, when a run of accepted samples with rssi < `cfg_low_thr` reaches `cfg_dwell_len` in length. The run restarts after a rise, a sample that is not below the threshold, a saturation, a jump, hold, or settling.
- R5: Saturation has priority over a jump, and a jump has priority over a rise. A step that the clamps reduce to no change counts as no gain change.
- R6: At every clock edge where `hold` is 1, `gain_code` stays unchanged. The baseline keeps tracking. After release, tracking continues from the frozen code.
- R7: After a gain change, `gain_stable` is 0 for exactly `cfg_settle_len` accepted samples and is 1 again after that. A value of 0 keeps the flag high. A change made on the edge just before hold rises still gets its full settling window.
- R8: While `gain_stable` is 0, no sample causes a gain change.
- R9: The only thing that gates tracking is `smp_vld`. A cycle with `smp_vld`=0 changes neither the gain, nor the baseline, nor the settling count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample accepted this cycle |
| rssi | input | RW (8) | Received power value |
| smp_i | input | SW (12) | Signed in-phase sample |
| smp_q | input | SW (12) | Signed quadrature sample |
| hold | input | 1 | Software freeze of the gain |
| cfg_step_thr | input | RW | RSSI rise over baseline that counts as a jump |
| cfg_low_thr | input | RW | RSSI level below which decay counts |
| cfg_gain_min | input | GW (6) | Lowest gain code |
| cfg_gain_max | input | GW | Highest gain code |
| cfg_gain_step | input | GW | Gain change per step |
| cfg_settle_len | input | STW (8) | Settling window in accepted samples |
| cfg_dwell_len | input | DW (16) | Quiet run length before a rise |
| gain_code | output | GW | Gain code to the radio |
| gain_stable | output | 1 | Gain settled; sample usable |

## Verification
Every decision is registered on the edge where its sample is accepted. A new `gain_code` is therefore visible one clock after the sample, and `gain_stable` falls in that same cycle. The flag then rises again once `cfg_settle_len` more accepted samples have passed. The bench sets inputs on the falling edge and advances its reference model just after the rising edge. It compares both outputs at the following falling edge, so each expectation is checked in the cycle where it first becomes due.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_SAT   = 2'd1,
    ACT_JUMP  = 2'd2,
    ACT_DECAY = 2'd3
  } agc_act_e;
endpackage

// File: rtl/agc_baseline.sv
module agc_baseline #(
  parameter int RW    = 8,
  parameter int SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          snap,
  input  logic [RW-1:0] rssi,
  input  logic [RW-1:0] step_thr,
  output logic          jump
);
  logic [RW-1:0]        base_q, base_d;
  logic signed [RW:0]   diff;
  logic signed [RW:0]   delta;

  always_comb begin
    diff   = $signed({1'b0, rssi}) - $signed({1'b0, base_q});
    delta  = diff >>> SHIFT;
    base_d = base_q;
    if (en) begin
      if (snap) base_d = rssi;
      else      base_d = RW'($signed({1'b0, base_q}) + delta);
    end
  end

  assign jump = ({1'b0, rssi} > ({1'b0, base_q} + {1'b0, step_thr}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end
endmodule

// File: rtl/agc_dwell.sv
module agc_dwell #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          below,
  input  logic          clr,
  input  logic [DW-1:0] dwell_len,
  output logic          expire
);
  logic [DW-1:0] cnt_q, cnt_d;

  assign expire = below && (({1'b0, cnt_q} + 1'b1) >= {1'b0, dwell_len});

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (clr || !below || expire) cnt_d = '0;
      else                         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/agc_settle.sv
module agc_settle #(
  parameter int STW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           load,
  input  logic [STW-1:0] settle_len,
  output logic           stable
);
  logic [STW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = settle_len;
    else if (en && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  assign stable = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/agc_track.sv
module agc_track #(
  parameter int RW        = 8,
  parameter int SW        = 12,
  parameter int GW        = 6,
  parameter int STW       = 8,
  parameter int DW        = 16,
  parameter int GAIN_INIT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [RW-1:0] rssi,
  input  logic [SW-1:0] smp_i,
  input  logic [SW-1:0] smp_q,
  input  logic          hold,
  input  logic [RW-1:0] cfg_step_thr,
  input  logic [RW-1:0] cfg_low_thr,
  input  logic [GW-1:0] cfg_gain_min,
  input  logic [GW-1:0] cfg_gain_max,
  input  logic [GW-1:0] cfg_gain_step,
  input  logic [STW-1:0] cfg_settle_len,
  input  logic [DW-1:0] cfg_dwell_len,
  output logic [GW-1:0] gain_code,
  output logic          gain_stable
);
  import agc_pkg::*;

  localparam logic signed [SW-1:0] FS_POS = SW'((1 << (SW-1)) - 1);
  localparam logic signed [SW-1:0] FS_NEG = -FS_POS;

  logic          sat, jump, expire, elig;
  logic [GW-1:0] gain_q, gain_d, gain_dn, gain_up;
  logic          change;
  agc_act_e      act;

  always_comb begin
    sat = ($signed(smp_i) >= FS_POS) || ($signed(smp_i) <= FS_NEG) ||
          ($signed(smp_q) >= FS_POS) || ($signed(smp_q) <= FS_NEG);
  end

  assign elig = smp_vld && !hold && gain_stable;

  agc_baseline #(.RW(RW), .SHIFT(3)) u_base (
    .clk(clk), .rst_n(rst_n), .en(smp_vld), .snap(act == ACT_JUMP),
    .rssi(rssi), .step_thr(cfg_step_thr), .jump(jump)
  );

  agc_dwell #(.DW(DW)) u_dwell (
    .clk(clk), .rst_n(rst_n), .en(smp_vld), .below(rssi < cfg_low_thr),
    .clr(!elig || sat || jump), .dwell_len(cfg_dwell_len), .expire(expire)
  );

  always_comb begin
    if (elig && sat)                  act = ACT_SAT;
    else if (elig && jump)            act = ACT_JUMP;
    else if (elig && expire)          act = ACT_DECAY;
    else                              act = ACT_NONE;
  end

  always_comb begin
    if ({1'b0, gain_q} >= ({1'b0, cfg_gain_min} + {1'b0, cfg_gain_step}))
      gain_dn = gain_q - cfg_gain_step;
    else
      gain_dn = cfg_gain_min;
    if (({1'b0, gain_q} + {1'b0, cfg_gain_step}) <= {1'b0, cfg_gain_max})
      gain_up = gain_q + cfg_gain_step;
    else
      gain_up = cfg_gain_max;
    case (act)
      ACT_SAT, ACT_JUMP: gain_d = gain_dn;
      ACT_DECAY:         gain_d = gain_up;
      default:           gain_d = gain_q;
    endcase
    change = (gain_d != gain_q);
  end

  agc_settle #(.STW(STW)) u_settle (
    .clk(clk), .rst_n(rst_n), .en(smp_vld), .load(change),
    .settle_len(cfg_settle_len), .stable(gain_stable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gain_q <= GW'(GAIN_INIT);
    else if (change) gain_q <= gain_d;
  end

  assign gain_code = gain_q;
endmodule

// File: rtl/agc_track_chk.sv
module agc_track_chk #(
  parameter int SW = 12,
  parameter int GW = 6,
  parameter int STW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           smp_vld,
  input logic [SW-1:0]  smp_i,
  input logic [SW-1:0]  smp_q,
  input logic           hold,
  input logic [GW-1:0]  cfg_gain_min,
  input logic [GW-1:0]  cfg_gain_max,
  input logic [STW-1:0] cfg_settle_len,
  input logic [GW-1:0]  gain_code,
  input logic           gain_stable
);
  localparam logic signed [SW-1:0] FSP = SW'((1 << (SW-1)) - 1);
  logic smp_sat;
  assign smp_sat = ($signed(smp_i) >= FSP) || ($signed(smp_i) <= -FSP) ||
                   ($signed(smp_q) >= FSP) || ($signed(smp_q) <= -FSP);

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(gain_code)); // R6
  AST_SETTLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(gain_code) && $past(cfg_settle_len) != '0) |-> !gain_stable); // R7
  AST_NO_CHANGE_UNSTABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_stable |=> $stable(gain_code)); // R8
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(gain_code)); // R9
  AST_SAT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && smp_sat) |=> (gain_code <= $past(gain_code))); // R2
  AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(gain_code) && cfg_gain_min <= cfg_gain_max) |->
      (gain_code >= cfg_gain_min && gain_code <= cfg_gain_max)); // R5
endmodule

bind agc_track agc_track_chk #(.SW(SW), .GW(GW), .STW(STW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
  .hold(hold), .cfg_gain_min(cfg_gain_min), .cfg_gain_max(cfg_gain_max),
  .cfg_settle_len(cfg_settle_len), .gain_code(gain_code), .gain_stable(gain_stable)
);

// File: tb/agc_track_tb.sv
module agc_track_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 8, SW = 12, GW = 6, STW = 8, DW = 16;
  localparam int FS = (1 << (SW-1)) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_vld = 1'b0, hold = 1'b0;
  logic [RW-1:0] rssi = '0;
  logic [SW-1:0] smp_i = '0, smp_q = '0;
  logic [RW-1:0] cfg_step_thr = 8'd20, cfg_low_thr = 8'd40;
  logic [GW-1:0] cfg_gain_min = 6'd8, cfg_gain_max = 6'd50, cfg_gain_step = 6'd3;
  logic [STW-1:0] cfg_settle_len = 8'd4;
  logic [DW-1:0] cfg_dwell_len = 16'd6;
  logic [GW-1:0] gain_code;
  logic gain_stable;

  int n_tests = 0, n_fail = 0;
  int m_gain, m_base, m_dwell, m_settle;
  string cur_req = "R1";
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_track #(.RW(RW), .SW(SW), .GW(GW), .STW(STW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .rssi(rssi), .smp_i(smp_i),
    .smp_q(smp_q), .hold(hold), .cfg_step_thr(cfg_step_thr), .cfg_low_thr(cfg_low_thr),
    .cfg_gain_min(cfg_gain_min), .cfg_gain_max(cfg_gain_max), .cfg_gain_step(cfg_gain_step),
    .cfg_settle_len(cfg_settle_len), .cfg_dwell_len(cfg_dwell_len),
    .gain_code(gain_code), .gain_stable(gain_stable)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_sat(input int v);
    return (v >= FS) || (v <= -FS);
  endfunction

  task automatic model_edge();
    int r, newg;
    bit sat, jmp, below, elig, exp_up, act_sat, act_jmp;
    if (!smp_vld) return;
    r = int'(rssi);
    sat = is_sat(int'($signed(smp_i))) || is_sat(int'($signed(smp_q)));
    elig = !hold && (m_settle == 0);
    jmp = r > m_base + int'(cfg_step_thr);
    below = r < int'(cfg_low_thr);
    act_sat = elig && sat;
    act_jmp = elig && !sat && jmp;
    exp_up = elig && !sat && !jmp && below && (m_dwell + 1 >= int'(cfg_dwell_len));
    newg = m_gain;
    if (act_sat || act_jmp)
      newg = (m_gain >= int'(cfg_gain_min) + int'(cfg_gain_step)) ? m_gain - int'(cfg_gain_step) : int'(cfg_gain_min);
    else if (exp_up)
      newg = (m_gain + int'(cfg_gain_step) <= int'(cfg_gain_max)) ? m_gain + int'(cfg_gain_step) : int'(cfg_gain_max);
    if (!elig || sat || jmp || !below || exp_up) m_dwell = 0;
    else m_dwell++;
    if (act_jmp) m_base = r;
    else m_base = m_base + ((r - m_base) >>> 3);
    if (newg != m_gain) m_settle = int'(cfg_settle_len);
    else if (m_settle > 0) m_settle--;
    m_gain = newg;
  endtask

  task automatic cyc(input bit v, input int r, input int i, input int q, input bit h);
    @(negedge clk);
    check(cur_req, int'(gain_code), m_gain, "gain_code");
    check(cur_req, int'(gain_stable), int'(m_settle == 0), "gain_stable");
    smp_vld = v; rssi = RW'(r); smp_i = SW'(i); smp_q = SW'(q); hold = h;
    @(posedge clk);
    #1 model_edge();
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int frozen;
    void'($urandom(32'd1234));
    m_gain = 32; m_base = 0; m_dwell = 0; m_settle = 0;
    #(CLK_PERIOD*2);
    check("R1", int'(gain_code), 32, "reset gain");
    check("R1", int'(gain_stable), 1, "reset stable");
    @(negedge clk); rst_n = 1'b1;
    // R3: first sample far above a zero baseline is a jump
    cur_req = "R3";
    for (int k = 0; k < 12; k++) cyc(1, 100, 5, -5, 0);
    // R2: saturated sample on a quiet level
    cur_req = "R2";
    cyc(1, 100, FS, 0, 0);
    cyc(1, 100, 0, 0, 0);
    check("R2", int'(gain_code), m_gain, "after saturation");
    // R8: saturation while settling does nothing
    cur_req = "R8";
    for (int k = 0; k < 6; k++) cyc(1, 100, 0, -FS, 0);
    // R4/R5: quiet RSSI decays gain up to the max clamp
    cur_req = "R4";
    for (int k = 0; k < 150; k++) cyc(1, 10, 1, 1, 0);
    check("R5", int'(gain_code), 50, "gain at max clamp");
    // R6: hold freezes through saturation and jumps
    cur_req = "R6";
    frozen = m_gain;
    for (int k = 0; k < 10; k++) cyc(1, (k % 2) ? 250 : 10, FS, FS, 1);
    cyc(1, 10, 0, 0, 0);
    check("R6", int'(gain_code), frozen, "gain frozen by hold");
    for (int k = 0; k < 8; k++) cyc(1, 60, 0, 0, 0);
    // R7: change on the edge before hold still settles; then zero window
    cur_req = "R7";
    cyc(1, 60, FS, 0, 0);
    for (int k = 0; k < 6; k++) cyc(1, 60, 0, 0, 1);
    cyc(1, 60, 0, 0, 0);
    cfg_settle_len = 8'd0;
    // R5: zero window, saturation drives gain to the min clamp, clamped no-op
    cur_req = "R5";
    for (int k = 0; k < 20; k++) cyc(1, 60, -FS-1, 0, 0);
    check("R5", int'(gain_code), 8, "gain at min clamp");
    check("R7", int'(gain_stable), 1, "zero window keeps stable");
    // R9: no accepted sample -> no effect
    cur_req = "R9";
    cfg_settle_len = 8'd3;
    frozen = m_gain;
    for (int k = 0; k < 10; k++) cyc(0, 250, FS, FS, 0);
    check("R9", int'(gain_code), frozen, "idle samples ignored");
    // random mix
    cur_req = "R5";
    cfg_settle_len = 8'd5;
    for (int k = 0; k < 4000; k++) begin
      int r, i;
      r = ($urandom % 8 == 0) ? int'($urandom % 256) : 20 + int'($urandom % 40);
      i = ($urandom % 30 == 0) ? FS : int'($urandom % 200) - 100;
      cyc(($urandom % 5) != 0, r, i, int'($urandom % 200) - 100, ($urandom % 20) == 0);
    end
    cyc(0, 0, 0, 0, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule